// File: doc/BRIEF.md
# Calendar Timekeeper with Alarm Match

This block holds a wall-clock time and calendar in ten bytes that software reads and writes: seconds, minutes, hours, day of week, date, month, year and three alarm bytes. A control byte selects binary or BCD coding, 12- or 24-hour hours, an automatic daylight-saving adjustment and a freeze bit. Each pulse on the once-per-second tick input advances an internal count. Unless the freeze bit is set, the new time is then copied into the user bytes.

While the block is frozen, software may rewrite the user bytes at leisure and the internal count keeps running. Clearing the freeze bit copies the user bytes into the internal count. A pre-tick input warns that a tick is coming and raises an update-in-progress flag. Every tick compares the new time with the alarm bytes, and an alarm byte whose two top bits are both set matches any value.

Top module: `cal_timekeeper`

## Requirements
- R1: Register map: address 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 control (bit0 freeze, bit1 binary coding, bit2 24-hour, bit3 daylight saving, bit7 update-in-progress, read-only). After reset the bytes read 00,00,00,01,01,01,00,00,00,00 and control reads 0x04.
- R2: A tick advances the seconds. Seconds and minutes wrap 59 to 0 with a carry, and hours wrap 23 to 0. At midnight the weekday goes 7 to 1 (1 is Sunday) and the date advances.
- R3: The date wraps to 1 after the last day of the month: 30 for April, June, September and November, 31 for the other months, and for February 29 when the year modulo 4 is 0, else 28. Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R4: Control bit1 = 1 codes every time, calendar and alarm byte in binary; bit1 = 0 codes them in BCD.
- R5: With control bit2 = 0 the hours byte carries 1 to 12 with bit7 = 1 for PM. 11:59:59 AM is followed by 12:00:00 PM, and 11:59:59 PM is followed by 12:00:00 AM together with a date advance.
- R6: After a tick, the alarm fires when each alarm byte equals its time byte or has its two top bits set.
- R7: The alarm and update-ended outputs are single-cycle pulses in the cycle after the tick.
- R8: With bit3 set, a tick at 01:59:59 on a Sunday in April with date 1 to 7 goes to 03:00:00. On a Sunday with bit3 clear, or on any other weekday, the same tick goes to 02:00:00.
- R9: With bit3 set, on a Sunday in October with date 25 to 31, the first tick at 01:59:59 goes to 01:00:00 and the second goes to 02:00:00.
- R10: While frozen the user bytes change only by software writes, the internal count keeps advancing and the alarm is judged on it. Clearing the freeze bit loads the user bytes into the internal count.
- R11: The pre-tick input sets the update-in-progress flag, and a tick clears it. Setting the freeze bit clears it, and while frozen the pre-tick input has no effect.
- R12: Bit 7 of the seconds byte always reads 0, whatever is written to it.
- R13: The update-ended pulse follows a tick only when the freeze bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| pretick_i | input | 1 | One-cycle warning that a tick is near |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| uip_o | output | 1 | Update-in-progress flag |
| upd_end_o | output | 1 | Pulse after a transfer into the user bytes |
| alarm_o | output | 1 | Alarm match pulse |

## Verification
Two situations are hard to reach. The first is the second pass through 01:59:59 on an autumn change day. After the backward jump the bench ticks 3599 times so that the block reaches that time again on its own. Rewriting the time would reload the count and forget that the jump was taken.

The second is the internal count running while the user bytes are frozen. That count has no read path. The bench sets a seconds-only alarm a few seconds ahead, keeps the block frozen and watches the alarm pulse arrive while the seconds byte stays still.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
// Shared types and coding helpers for the calendar timekeeper.
// Assumes: all internal fields are plain binary, and years run 0..99.
package cal_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_TIME  = 7;
    localparam int N_ALARM = 3;
    localparam int N_BYTES = N_TIME + N_ALARM;
    localparam int ADDR_W  = 4;
    localparam int IDX_SEC = 0;
    localparam int IDX_WD  = 3;
    localparam int IDX_DT  = 4;
    localparam int IDX_MO  = 5;
    localparam int IDX_CTL = N_BYTES;

    typedef struct packed {
        logic [6:0] yr;
        logic [3:0] mon;
        logic [4:0] dt;
        logic [2:0] wd;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } cal_time_t;

    localparam cal_time_t TIME_RST = '{yr: 7'd0, mon: 4'd1, dt: 5'd1, wd: 3'd1,
                                       hr: 5'd0, mn: 6'd0, sc: 6'd0};

    // Binary value to byte in binary or BCD coding.
    function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
        logic [6:0] t;
        logic [6:0] o;
        t = v / 7'd10;
        o = v - t * 7'd10;
        return bin ? {1'b0, v} : {t[3:0], o[3:0]};
    endfunction

    // Byte in binary or BCD coding to binary value.
    function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
        return bin ? b[6:0] : ({3'b0, b[7:4]} * 7'd10) + {3'b0, b[3:0]};
    endfunction

    // Hours 0..23 to the hours byte in 24- or 12-hour form.
    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin, input logic h24);
        logic [4:0] h12;
        logic pm;
        pm  = (h >= 5'd12);
        h12 = pm ? h - 5'd12 : h;
        if (h12 == 5'd0) h12 = 5'd12;
        if (h24) return enc_val({2'b0, h}, bin);
        return enc_val({2'b0, h12}, bin) | {pm, 7'b0};
    endfunction

    // Hours byte in 24- or 12-hour form to hours 0..23.
    function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
        logic [6:0] v;
        logic [4:0] h;
        v = h24 ? dec_val(b, bin) : dec_val({1'b0, b[6:0]}, bin);
        h = v[4:0];
        if (!h24) begin
            if (v == 7'd12) h = 5'd0;
            if (b[7]) h = h + 5'd12;
        end
        return h;
    endfunction

    // Days in a month; the year is leap when it is a multiple of four.
    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
        case (mon)
            4'd2:                      return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_next_time.sv
`timescale 1ns/1ps
// Next-second calculator: carry chain through the calendar plus the
// daylight-saving jumps. Purely combinational.
// Assumes: the caller says whether the autumn jump was already taken today.
module cal_next_time
    import cal_pkg::*;
(
    input  cal_time_t cur_i,
    input  logic      dst_en_i,
    input  logic      fall_done_i,
    output cal_time_t nxt_o,
    output logic      fall_jump_o,
    output logic      day_roll_o
);
    logic       at_0159;
    logic       spring;
    logic       fall;
    logic [4:0] mdays;

    assign mdays   = month_days(cur_i.mon, cur_i.yr);
    assign at_0159 = (cur_i.hr == 5'd1) && (cur_i.mn == 6'd59) && (cur_i.sc == 6'd59);
    assign spring  = dst_en_i && at_0159 && (cur_i.mon == 4'd4) && (cur_i.wd == 3'd1)
                     && (cur_i.dt <= 5'd7);
    assign fall    = dst_en_i && at_0159 && (cur_i.mon == 4'd10) && (cur_i.wd == 3'd1)
                     && (cur_i.dt >= 5'd25) && !fall_done_i;

    // Pick a jump or walk the carry chain from seconds up to years.
    always_comb begin
        nxt_o       = cur_i;
        fall_jump_o = 1'b0;
        day_roll_o  = 1'b0;
        if (spring) begin
            nxt_o.hr = 5'd3;
            nxt_o.mn = 6'd0;
            nxt_o.sc = 6'd0;
        end else if (fall) begin
            nxt_o.hr    = 5'd1;
            nxt_o.mn    = 6'd0;
            nxt_o.sc    = 6'd0;
            fall_jump_o = 1'b1;
        end else if (cur_i.sc < 6'd59) begin
            nxt_o.sc = cur_i.sc + 6'd1;
        end else begin
            nxt_o.sc = 6'd0;
            if (cur_i.mn < 6'd59) begin
                nxt_o.mn = cur_i.mn + 6'd1;
            end else begin
                nxt_o.mn = 6'd0;
                if (cur_i.hr < 5'd23) begin
                    nxt_o.hr = cur_i.hr + 5'd1;
                end else begin
                    nxt_o.hr   = 5'd0;
                    day_roll_o = 1'b1;
                    nxt_o.wd   = (cur_i.wd >= 3'd7) ? 3'd1 : cur_i.wd + 3'd1;
                    if (cur_i.dt < mdays) begin
                        nxt_o.dt = cur_i.dt + 5'd1;
                    end else begin
                        nxt_o.dt = 5'd1;
                        if (cur_i.mon < 4'd12) begin
                            nxt_o.mon = cur_i.mon + 4'd1;
                        end else begin
                            nxt_o.mon = 4'd1;
                            nxt_o.yr  = (cur_i.yr >= 7'd99) ? 7'd0 : cur_i.yr + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_alarm_cmp.sv
`timescale 1ns/1ps
// Alarm comparator: one lane per alarm byte. A lane matches on an equal
// byte or on a byte whose two top bits are set. Combinational.
// Assumes: the time and alarm bytes use the same coding.
module cal_alarm_cmp #(
    parameter int N_FIELD = 3,
    parameter int W       = 8
) (
    input  logic [N_FIELD-1:0][W-1:0] alarm_i,
    input  logic [N_FIELD-1:0][W-1:0] time_i,
    output logic                      hit_o
);
    logic [N_FIELD-1:0] lane_ok;

    for (genvar i = 0; i < N_FIELD; i++) begin : g_lane
        // One lane: the wildcard code or an exact match.
        assign lane_ok[i] = (alarm_i[i][W-1 -: 2] == 2'b11) || (alarm_i[i] == time_i[i]);
    end

    assign hit_o = &lane_ok;
endmodule

// File: rtl/cal_user_regs.sv
`timescale 1ns/1ps
// Software-visible time and alarm bytes. A transfer from the internal
// count overrides a software write to a time byte in the same cycle.
// Assumes: the caller blocks transfers while the block is frozen.
module cal_user_regs
    import cal_pkg::*;
#(
    parameter int N_T = N_TIME,
    parameter int N_A = N_ALARM,
    parameter int AW  = ADDR_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [AW-1:0]                wr_idx_i,
    input  logic [7:0]                   wr_data_i,
    input  logic                         xfer_i,
    input  logic [N_T-1:0][7:0]          xfer_bytes_i,
    output logic [N_T+N_A-1:0][7:0]      regs_o
);
    localparam int N_R = N_T + N_A;

    for (genvar i = 0; i < N_R; i++) begin : g_byte
        localparam logic [7:0] RST_V = (i == IDX_WD || i == IDX_DT || i == IDX_MO) ? 8'h01 : 8'h00;
        localparam logic [7:0] W_MSK = (i == IDX_SEC) ? 8'h7F : 8'hFF;
        logic [7:0] byte_q;
        logic       sw_wr;
        assign sw_wr     = wr_en_i && (wr_idx_i == AW'(i));
        assign regs_o[i] = byte_q;
        if (i < N_T) begin : g_time
            // Time byte: a transfer wins over a software write.
            always_ff @(posedge clk) begin
                if (!rst_n)      byte_q <= RST_V;
                else if (xfer_i) byte_q <= xfer_bytes_i[i];
                else if (sw_wr)  byte_q <= wr_data_i & W_MSK;
            end
        end else begin : g_alarm
            // Alarm byte: changed only by software.
            always_ff @(posedge clk) begin
                if (!rst_n)     byte_q <= RST_V;
                else if (sw_wr) byte_q <= wr_data_i;
            end
        end
    end

    // R12
    sec_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[IDX_SEC][7] == 1'b0);
endmodule

// File: rtl/cal_timekeeper.sv
`timescale 1ns/1ps
// Calendar timekeeper top: internal binary count, control byte,
// update-in-progress flag, coding between the internal count and the
// user bytes, and the alarm and update-ended pulses.
// Assumes: tick_i and pretick_i are single-cycle pulses, synchronous to clk.
module cal_timekeeper
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        pretick_i,
    input  logic        reg_we_i,
    input  logic [3:0]  reg_addr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    output logic        uip_o,
    output logic        upd_end_o,
    output logic        alarm_o
);
    logic freeze_q, bin_q, h24_q, dst_q, uip_q;
    logic alarm_q, upd_end_q, fall_done_q;
    logic ctl_wr, load, xfer, fd_base, fall_jump, day_roll, hit;
    cal_time_t now_q, user_t, base_t, nxt_t;
    logic [N_BYTES-1:0][7:0] user_b;
    logic [N_TIME-1:0][7:0]  nxt_b;

    assign ctl_wr  = reg_we_i && (reg_addr_i == ADDR_W'(IDX_CTL));
    assign load    = ctl_wr && freeze_q && !reg_wdata_i[0];
    assign xfer    = tick_i && !freeze_q;
    assign base_t  = load ? user_t : now_q;
    assign fd_base = load ? 1'b0 : fall_done_q;

    // Decode the user bytes into an internal count for the unfreeze load.
    always_comb begin
        user_t.sc  = 6'(dec_val(user_b[0], bin_q));
        user_t.mn  = 6'(dec_val(user_b[1], bin_q));
        user_t.hr  = dec_hour(user_b[2], bin_q, h24_q);
        user_t.wd  = 3'(dec_val(user_b[3], bin_q));
        user_t.dt  = 5'(dec_val(user_b[4], bin_q));
        user_t.mon = 4'(dec_val(user_b[5], bin_q));
        user_t.yr  = dec_val(user_b[6], bin_q);
    end

    // Encode the next count into user-byte coding.
    always_comb begin
        nxt_b[0] = enc_val({1'b0, nxt_t.sc}, bin_q);
        nxt_b[1] = enc_val({1'b0, nxt_t.mn}, bin_q);
        nxt_b[2] = enc_hour(nxt_t.hr, bin_q, h24_q);
        nxt_b[3] = enc_val({4'b0, nxt_t.wd}, bin_q);
        nxt_b[4] = enc_val({2'b0, nxt_t.dt}, bin_q);
        nxt_b[5] = enc_val({3'b0, nxt_t.mon}, bin_q);
        nxt_b[6] = enc_val(nxt_t.yr, bin_q);
    end

    cal_next_time u_next (
        .cur_i       (base_t),
        .dst_en_i    (dst_q),
        .fall_done_i (fd_base),
        .nxt_o       (nxt_t),
        .fall_jump_o (fall_jump),
        .day_roll_o  (day_roll)
    );

    cal_alarm_cmp #(.N_FIELD(N_ALARM), .W(BYTE_W)) u_alarm (
        .alarm_i (user_b[N_BYTES-1:N_TIME]),
        .time_i  (nxt_b[N_ALARM-1:0]),
        .hit_o   (hit)
    );

    cal_user_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (reg_we_i),
        .wr_idx_i     (reg_addr_i),
        .wr_data_i    (reg_wdata_i),
        .xfer_i       (xfer),
        .xfer_bytes_i (nxt_b),
        .regs_o       (user_b)
    );

    // Internal count: advances on every tick, frozen or not.
    always_ff @(posedge clk) begin
        if (!rst_n)      now_q <= TIME_RST;
        else if (tick_i) now_q <= nxt_t;
        else             now_q <= base_t;
    end

    // Remembers the autumn jump until the next midnight or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)         fall_done_q <= 1'b0;
        else if (fall_jump) fall_done_q <= tick_i | fd_base;
        else if (tick_i && day_roll) fall_done_q <= 1'b0;
        else                fall_done_q <= fd_base;
    end

    // Control byte fields.
    always_ff @(posedge clk) begin
        if (!rst_n)      {dst_q, h24_q, bin_q, freeze_q} <= 4'b0100;
        else if (ctl_wr) {dst_q, h24_q, bin_q, freeze_q} <= reg_wdata_i[3:0];
    end

    // Update-in-progress flag between the warning and the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      uip_q <= 1'b0;
        else if (freeze_q || (ctl_wr && reg_wdata_i[0])) uip_q <= 1'b0;
        else if (tick_i)                                 uip_q <= 1'b0;
        else if (pretick_i)                              uip_q <= 1'b1;
    end

    // Output pulses one cycle after the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q   <= 1'b0;
            upd_end_q <= 1'b0;
        end else begin
            alarm_q   <= tick_i && hit;
            upd_end_q <= xfer;
        end
    end

    // Read mux over the user bytes and the control byte.
    always_comb begin
        if (reg_addr_i < ADDR_W'(N_BYTES))      reg_rdata_o = user_b[reg_addr_i];
        else if (reg_addr_i == ADDR_W'(IDX_CTL)) reg_rdata_o = {uip_q, 3'b000, dst_q, h24_q, bin_q, freeze_q};
        else                                     reg_rdata_o = 8'h00;
    end

    assign uip_o     = uip_q;
    assign upd_end_o = upd_end_q;
    assign alarm_o   = alarm_q;

    // R2
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (now_q.hr < 5'd24));
    // R2
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && day_roll) |=> (now_q.wd >= 3'd1 && now_q.wd <= 3'd7));
    // R10
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !reg_we_i) |=> $stable(user_b));
    // R11
    uip_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_q |-> !uip_q);
    // R7
    alarm_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> $past(tick_i));
endmodule

// File: tb/cal_timekeeper_tb.sv
`timescale 1ns/1ps
module cal_timekeeper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, pretick = 1'b0, we = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       uip, upd_end, alarm;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] mode = 8'h04;

    always #5 clk = ~clk;

    cal_timekeeper dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pretick_i(pretick),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .uip_o(uip), .upd_end_o(upd_end), .alarm_o(alarm)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic do_tick(output logic al, output logic ue);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; al = alarm; ue = upd_end;
    endtask

    task automatic tick1;
        logic a, u;
        do_tick(a, u);
    endtask

    task automatic set_time(input logic [7:0] h, mi, s, wd, dt, mo, yr);
        wr(4'd10, mode | 8'h01);
        wr(4'd0, s); wr(4'd1, mi); wr(4'd2, h);
        wr(4'd3, wd); wr(4'd4, dt); wr(4'd5, mo); wr(4'd6, yr);
        wr(4'd10, mode);
    endtask

    task automatic chk_hms(input string req, input logic [7:0] h, mi, s);
        logic [7:0] d;
        rd(4'd2, d); chk(req, d, h);
        rd(4'd1, d); chk(req, d, mi);
        rd(4'd0, d); chk(req, d, s);
    endtask

    task automatic chk_day(input string req, input logic [7:0] wd, dt, mo, yr);
        logic [7:0] d;
        rd(4'd3, d); chk(req, d, wd);
        rd(4'd4, d); chk(req, d, dt);
        rd(4'd5, d); chk(req, d, mo);
        rd(4'd6, d); chk(req, d, yr);
    endtask

    // R1: reset values of every byte.
    task automatic t_reset;
        logic [7:0] exp [11] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00,
                                 8'h00, 8'h00, 8'h00, 8'h04};
        logic [7:0] d;
        for (int i = 0; i < 11; i++) begin
            rd(4'(i), d); chk("R1 reset", d, exp[i]);
        end
        chk("R1 uip reset", {7'b0, uip}, 8'h00);
    endtask

    // R2, R3, R6, R13: carries, midnight, new year, exact alarm on 00:00:00.
    task automatic t_rollover;
        logic al, ue;
        mode = 8'h04;
        set_time(8'h10, 8'h29, 8'h59, 8'h03, 8'h15, 8'h06, 8'h40);
        do_tick(al, ue);
        chk_hms("R2 minute carry", 8'h10, 8'h30, 8'h00);
        chk("R13 update pulse", {7'b0, ue}, 8'h01);
        tick1;
        chk_hms("R2 plain second", 8'h10, 8'h30, 8'h01);
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick(al, ue);
        chk_hms("R2 midnight", 8'h00, 8'h00, 8'h00);
        chk_day("R3 new year", 8'h01, 8'h01, 8'h01, 8'h00);
        chk("R6 exact alarm", {7'b0, al}, 8'h01);
    endtask

    // R3: month lengths and leap years.
    task automatic t_months;
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24); tick1;
        chk_day("R3 leap feb 28", 8'h03, 8'h29, 8'h02, 8'h24);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h29, 8'h02, 8'h24); tick1;
        chk_day("R3 leap feb 29", 8'h03, 8'h01, 8'h03, 8'h24);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h23); tick1;
        chk_day("R3 common feb", 8'h03, 8'h01, 8'h03, 8'h23);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h00); tick1;
        chk_day("R3 year 00 leap", 8'h03, 8'h29, 8'h02, 8'h00);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h23); tick1;
        chk_day("R3 april 30", 8'h03, 8'h01, 8'h05, 8'h23);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h01, 8'h23); tick1;
        chk_day("R3 january 30", 8'h03, 8'h31, 8'h01, 8'h23);
    endtask

    // R4: binary versus BCD coding.
    task automatic t_coding;
        mode = 8'h06;
        set_time(8'h0C, 8'h3B, 8'h3B, 8'h01, 8'h0A, 8'h03, 8'h14); tick1;
        chk_hms("R4 binary carry", 8'h0D, 8'h00, 8'h00);
        set_time(8'h0C, 8'h00, 8'h09, 8'h01, 8'h0A, 8'h03, 8'h14); tick1;
        chk_hms("R4 binary 9->10", 8'h0C, 8'h00, 8'h0A);
        mode = 8'h04;
        set_time(8'h12, 8'h00, 8'h09, 8'h01, 8'h10, 8'h03, 8'h14); tick1;
        chk_hms("R4 bcd 9->10", 8'h12, 8'h00, 8'h10);
    endtask

    // R5: 12-hour coding and noon and midnight.
    task automatic t_12h;
        mode = 8'h00;
        set_time(8'h11, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h14); tick1;
        chk_hms("R5 noon", 8'h92, 8'h00, 8'h00);
        chk_day("R5 noon date kept", 8'h02, 8'h05, 8'h03, 8'h14);
        set_time(8'h91, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h14); tick1;
        chk_hms("R5 midnight", 8'h12, 8'h00, 8'h00);
        chk_day("R5 midnight date", 8'h03, 8'h06, 8'h03, 8'h14);
        set_time(8'h92, 8'h59, 8'h59, 8'h02, 8'h05, 8'h03, 8'h14); tick1;
        chk_hms("R5 12pm to 1pm", 8'h81, 8'h00, 8'h00);
        mode = 8'h04;
    endtask

    // R6, R7: wildcard and exact alarm matches, pulse width.
    task automatic t_alarm;
        logic al, ue;
        mode = 8'h04;
        wr(4'd7, 8'h30); wr(4'd8, 8'hC0); wr(4'd9, 8'hFF);
        set_time(8'h05, 8'h17, 8'h29, 8'h02, 8'h05, 8'h03, 8'h14);
        do_tick(al, ue);
        chk("R6 wildcard hit", {7'b0, al}, 8'h01);
        @(negedge clk);
        chk("R7 single cycle", {7'b0, alarm}, 8'h00);
        do_tick(al, ue);
        chk("R6 wildcard miss", {7'b0, al}, 8'h00);
        wr(4'd7, 8'h32); wr(4'd8, 8'h17); wr(4'd9, 8'h05);
        do_tick(al, ue);
        chk("R6 exact hit", {7'b0, al}, 8'h01);
        wr(4'd7, 8'h33); wr(4'd8, 8'h18);
        do_tick(al, ue);
        chk("R6 minute mismatch", {7'b0, al}, 8'h00);
        wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
        do_tick(al, ue);
        chk("R6 every second", {7'b0, al}, 8'h01);
        wr(4'd7, 8'h00); wr(4'd8, 8'h00); wr(4'd9, 8'h00);
    endtask

    // R8, R9: daylight-saving jumps.
    task automatic t_dst;
        mode = 8'h0C;
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h05, 8'h04, 8'h14); tick1;
        chk_hms("R8 spring jump", 8'h03, 8'h00, 8'h00);
        set_time(8'h01, 8'h59, 8'h59, 8'h02, 8'h05, 8'h04, 8'h14); tick1;
        chk_hms("R8 monday no jump", 8'h02, 8'h00, 8'h00);
        mode = 8'h04;
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h05, 8'h04, 8'h14); tick1;
        chk_hms("R8 disabled", 8'h02, 8'h00, 8'h00);
        mode = 8'h0C;
        set_time(8'h01, 8'h59, 8'h59, 8'h01, 8'h27, 8'h10, 8'h14); tick1;
        chk_hms("R9 autumn back", 8'h01, 8'h00, 8'h00);
        for (int i = 0; i < 3599; i++) tick1;
        chk_hms("R9 second pass", 8'h01, 8'h59, 8'h59);
        tick1;
        chk_hms("R9 no repeat", 8'h02, 8'h00, 8'h00);
        mode = 8'h04;
    endtask

    // R10, R11, R12, R13: freeze, unfreeze load, update flag, read-only bit.
    task automatic t_freeze;
        logic al, ue;
        logic [7:0] d;
        mode = 8'h04;
        wr(4'd7, 8'h13); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
        set_time(8'h00, 8'h00, 8'h10, 8'h02, 8'h05, 8'h03, 8'h14);
        wr(4'd10, 8'h05);
        do_tick(al, ue); chk("R10 frozen no alarm", {7'b0, al}, 8'h00);
        chk("R13 no update when frozen", {7'b0, ue}, 8'h00);
        do_tick(al, ue);
        do_tick(al, ue); chk("R10 internal alarm", {7'b0, al}, 8'h01);
        rd(4'd0, d); chk("R10 user frozen", d, 8'h10);
        wr(4'd10, 8'h04); tick1;
        rd(4'd0, d); chk("R10 unfreeze load", d, 8'h11);
        wr(4'd10, 8'h05); wr(4'd0, 8'h40); wr(4'd10, 8'h04); tick1;
        rd(4'd0, d); chk("R10 written load", d, 8'h41);
        wr(4'd7, 8'h00); wr(4'd8, 8'h00); wr(4'd9, 8'h00);
        @(negedge clk); pretick = 1'b1; @(negedge clk); pretick = 1'b0;
        rd(4'd10, d); chk("R11 uip set", d, 8'h84);
        chk("R11 uip port", {7'b0, uip}, 8'h01);
        tick1;
        rd(4'd10, d); chk("R11 uip cleared by tick", d, 8'h04);
        @(negedge clk); pretick = 1'b1; @(negedge clk); pretick = 1'b0;
        wr(4'd10, 8'h05);
        rd(4'd10, d); chk("R11 uip cleared by freeze", d, 8'h05);
        @(negedge clk); pretick = 1'b1; @(negedge clk); pretick = 1'b0;
        rd(4'd10, d); chk("R11 pretick ignored frozen", d, 8'h05);
        wr(4'd0, 8'hD5);
        rd(4'd0, d); chk("R12 seconds msb", d, 8'h55);
        wr(4'd10, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_rollover;
        t_months;
        t_coding;
        t_12h;
        t_alarm;
        t_dst;
        t_freeze;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule